// File: doc/BRIEF.md
# Serial Nonvolatile Memory Slave with Page Write Buffer

This block models a byte-addressed nonvolatile memory that answers as a slave on a four-wire serial bus. While chip select is low, the host shifts in an opcode MSB first, then a 16-bit address for the commands that take one, then data. Read data and status come back on the serial output. All pins are sampled by the system clock through synchronizers, so the serial clock must be slow against the system clock.

Written bytes first collect in a page buffer of `2**PAGE_AW` bytes. When chip select rises, a timed internal write cycle starts, and the bytes reach the array when the cycle ends. A status byte shows a busy flag, which the host can poll to learn early that a write has finished. It also shows a write-enable latch and a two-bit protection field. The protection field makes writes into an upper region of the array vanish without any effect. The block works the same whether the serial clock rests low or high between transfers.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset, `so` is 0, the status byte is 0x00 and every array byte reads 0x00.
- R2: SI is captured on each rising SCK edge and SO moves to the next bit on each falling SCK edge, MSB first. Transfers work the same whether SCK rests low or high while `cs_n` is high, and `so` is 0 while `cs_n` is high.
- R3: Opcode 0x05 returns the status byte {4'b0, guard[1:0], wel, wip} (bit 0 busy, bit 1 write enable, bits 3:2 guard). The byte is refreshed for every further byte clocked in the same transaction.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect once its opcode byte is complete.
- R5: Opcode 0x03 with address A returns array bytes from A[MEM_AW-1:0] upward. Higher address bits are ignored, and the address wraps from the last byte to byte 0.
- R6: Opcode 0x02 with address A and data bytes d0..dn writes byte di to page base + ((A offset + i) mod 2**PAGE_AW). A later byte overwrites an earlier one at the same position, and bytes of the page that receive no data keep their value.
- R7: A write (0x02) or status write (0x01) issued while the write-enable latch is 0 has no effect.
- R8: A write cycle starts when `cs_n` rises. The busy flag then stays 1 for TWR_CYC system cycles. When the flag falls, the array or guard field is updated and the write-enable latch is cleared.
- R9: While the busy flag is 1, every opcode except 0x05 is ignored. A read returns 0x00 bytes, and a write or status write changes nothing.
- R10: Opcode 0x01 followed by a byte v loads v[3:2] into the guard field at the end of its write cycle. The other bits of v are ignored.
- R11: The guard field protects part of the array: 01 protects the top quarter, 10 the top half, 11 the whole array. A write into a protected page starts no cycle and leaves the write-enable latch set.
- R12: An unknown opcode changes nothing. A write starts no cycle, and the write-enable latch stays set, if no complete data byte was sent or if `cs_n` rises in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |

## Verification
Each pin passes through a two-stage synchronizer plus one edge register before anything happens. A new SO bit therefore appears about three system cycles after the falling SCK edge. The bench holds each SCK phase for five system cycles and samples SO just before it raises SCK, so a late bit would be caught. The status byte is loaded when its opcode byte completes, so a poll reports the busy flag as it was at that moment. The bench records the cycle at which it raised chip select after a write. It then requires the first poll that reads "not busy" to arrive no sooner than TWR_CYC cycles later, and within two poll lengths of that point.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_AHI, PH_ALO, PH_RDATA, PH_WDATA, PH_SRDATA, PH_RDSR, PH_SKIP
  } phase_e;

  // top2: the two most significant array address bits
  function automatic logic in_guard(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   in_guard = 1'b0;
      2'b01:   in_guard = (top2 == 2'b11);
      2'b10:   in_guard = top2[1];
      default: in_guard = 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] stat_byte(input logic wip, input logic wel, input logic [1:0] bp);
    stat_byte = {4'b0000, bp, wel, wip};
  endfunction
endpackage

// File: rtl/spi_ee_edge.sv
module spi_ee_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_act,
  output logic cs_begin,
  output logic cs_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [STAGES-1:0] cs_p, sck_p, si_p;
  logic cs_prev, sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p     <= '1;
      sck_p    <= '0;
      si_p     <= '0;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_p     <= {cs_p[STAGES-2:0], cs_n};
      sck_p    <= {sck_p[STAGES-2:0], sck};
      si_p     <= {si_p[STAGES-2:0], si};
      cs_prev  <= cs_p[STAGES-1];
      sck_prev <= sck_p[STAGES-1];
    end
  end

  assign cs_act   = ~cs_p[STAGES-1];
  assign cs_begin = ~cs_p[STAGES-1] & cs_prev;
  assign cs_end   = cs_p[STAGES-1] & ~cs_prev;
  assign sck_rise = cs_act & sck_p[STAGES-1] & ~sck_prev;
  assign sck_fall = cs_act & ~sck_p[STAGES-1] & sck_prev;
  assign si_s     = si_p[STAGES-1];
endmodule

// File: rtl/spi_ee_status.sv
module spi_ee_status #(
  parameter int TWR_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       start_page,
  input  logic       start_sr,
  input  logic [1:0] sr_bp,
  output logic       wip,
  output logic       wel,
  output logic [1:0] bp,
  output logic       commit
);
  localparam int TW = $clog2(TWR_CYC + 1);
  localparam int RW = TW + 1;
  localparam logic [TW-1:0] TMR_LOAD = TW'(TWR_CYC - 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(TWR_CYC);

  logic [TW-1:0] tmr;
  logic          kind_sr;
  logic [1:0]    bp_hold;
  logic          done;
  logic          start;

  assign start  = start_page | start_sr;
  assign done   = wip && (tmr == '0);
  assign commit = done && !kind_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip     <= 1'b0;
      wel     <= 1'b0;
      bp      <= 2'b00;
      tmr     <= '0;
      kind_sr <= 1'b0;
      bp_hold <= 2'b00;
    end else begin
      if (set_wel)      wel <= 1'b1;
      else if (clr_wel) wel <= 1'b0;
      if (start) begin
        wip     <= 1'b1;
        tmr     <= TMR_LOAD;
        kind_sr <= start_sr;
        bp_hold <= sr_bp;
      end else if (done) begin
        wip <= 1'b0;
        wel <= 1'b0;
        if (kind_sr) bp <= bp_hold;
      end else if (wip) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  // independent cycle count of the busy window
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (start)  run_len <= RW'(1);
    else if (wip)    run_len <= run_len + 1'b1;
  end

  // R8
  wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == RUN_FULL));
  // R8
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel);
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !wip);
  // R7
  start_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> wel);
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int MEM_AW  = 8,
  parameter int PAGE_AW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy,
  input  logic                      buf_clr,
  input  logic                      buf_we,
  input  logic [PAGE_AW-1:0]        buf_idx,
  input  logic [MEM_AW-PAGE_AW-1:0] buf_pg,
  input  logic [7:0]                buf_din,
  input  logic                      commit,
  input  logic [MEM_AW-1:0]         rd_addr,
  output logic [7:0]                rd_data
);
  localparam int MEM_BYTES  = 1 << MEM_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int PG_W       = MEM_AW - PAGE_AW;

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;
  logic [PG_W-1:0]       pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++)  mem[i]  <= 8'h00;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
      mask <= '0;
      pg_q <= '0;
    end else begin
      if (buf_clr) mask <= '0;
      if (buf_we) begin
        pbuf[buf_idx] <= buf_din;
        mask[buf_idx] <= 1'b1;
        pg_q          <= buf_pg;
      end
      if (commit) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (mask[i]) mem[{pg_q, PAGE_AW'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // R9
  buf_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);
  // R6
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (mask != '0));
endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave #(
  parameter int MEM_AW      = 8,
  parameter int PAGE_AW     = 5,
  parameter int TWR_CYC     = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so
);
  import spi_ee_pkg::*;

  localparam int PG_W = MEM_AW - PAGE_AW;

  function automatic logic [15:0] page_step(input logic [15:0] a);
    page_step = a;
    page_step[PAGE_AW-1:0] = a[PAGE_AW-1:0] + 1'b1;
  endfunction

  logic cs_act, cs_begin, cs_end, sck_rise, sck_fall, si_s;
  logic wip, wel, commit;
  logic [1:0] bp;

  phase_e      ph;
  logic [2:0]  cnt;
  logic [6:0]  sh;
  logic [7:0]  op;
  logic [15:0] addr;
  logic [7:0]  osh;
  logic        got;
  logic [1:0]  sr_new;

  logic [7:0]  rx;
  logic        byte_done;
  logic [15:0] alo_addr;
  logic [MEM_AW-1:0] rd_addr;
  logic [7:0]  rd_data;
  logic        set_wel, clr_wel, start_page, start_sr, buf_clr, buf_we;
  logic        guard_hit;

  spi_ee_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_act(cs_act), .cs_begin(cs_begin), .cs_end(cs_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  assign rx        = {sh, si_s};
  assign byte_done = sck_rise && (cnt == 3'd7);
  assign alo_addr  = {addr[15:8], rx};
  assign rd_addr   = (ph == PH_ALO) ? alo_addr[MEM_AW-1:0] : addr[MEM_AW-1:0];
  assign guard_hit = in_guard(bp, addr[MEM_AW-1 -: 2]);

  assign set_wel    = byte_done && (ph == PH_CMD) && !wip && (rx == OP_WREN);
  assign clr_wel    = byte_done && (ph == PH_CMD) && !wip && (rx == OP_WRDI);
  assign buf_clr    = byte_done && (ph == PH_ALO) && (op == OP_WRITE);
  assign buf_we     = byte_done && (ph == PH_WDATA);
  assign start_page = cs_end && (ph == PH_WDATA) && got && (cnt == 3'd0) && !guard_hit;
  assign start_sr   = cs_end && (ph == PH_SRDATA) && got && (cnt == 3'd0);

  spi_ee_status #(.TWR_CYC(TWR_CYC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
    .start_page(start_page), .start_sr(start_sr), .sr_bp(sr_new),
    .wip(wip), .wel(wel), .bp(bp), .commit(commit)
  );

  spi_ee_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(wip), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(addr[PAGE_AW-1:0]), .buf_pg(addr[MEM_AW-1:PAGE_AW]),
    .buf_din(rx), .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_CMD;
      cnt    <= 3'd0;
      sh     <= 7'd0;
      op     <= 8'h00;
      addr   <= 16'h0000;
      osh    <= 8'h00;
      got    <= 1'b0;
      sr_new <= 2'b00;
      so     <= 1'b0;
    end else begin
      if (cs_begin) begin
        ph  <= PH_CMD;
        cnt <= 3'd0;
        got <= 1'b0;
        osh <= 8'h00;
      end else if (sck_rise) begin
        cnt <= cnt + 3'd1;
        sh  <= {sh[5:0], si_s};
        if (cnt == 3'd7) begin
          case (ph)
            PH_CMD: begin
              op <= rx;
              if (wip && rx != OP_RDSR) ph <= PH_SKIP;
              else begin
                case (rx)
                  OP_RDSR:  begin ph <= PH_RDSR; osh <= stat_byte(wip, wel, bp); end
                  OP_READ:  ph <= PH_AHI;
                  OP_WRITE: ph <= wel ? PH_AHI : PH_SKIP;
                  OP_WRSR:  ph <= wel ? PH_SRDATA : PH_SKIP;
                  default:  ph <= PH_SKIP;
                endcase
              end
            end
            PH_AHI: begin
              addr[15:8] <= rx;
              ph         <= PH_ALO;
            end
            PH_ALO: begin
              if (op == OP_READ) begin
                osh  <= rd_data;
                addr <= alo_addr + 16'd1;
                ph   <= PH_RDATA;
              end else begin
                addr <= alo_addr;
                ph   <= PH_WDATA;
              end
            end
            PH_RDATA: begin
              osh  <= rd_data;
              addr <= addr + 16'd1;
            end
            PH_WDATA: begin
              addr <= page_step(addr);
              got  <= 1'b1;
            end
            PH_SRDATA: begin
              sr_new <= rx[3:2];
              got    <= 1'b1;
            end
            PH_RDSR: osh <= stat_byte(wip, wel, bp);
            default: ;
          endcase
        end
      end
      if (!cs_act) so <= 1'b0;
      else if (sck_fall) begin
        so  <= osh[7];
        osh <= {osh[6:0], 1'b0};
      end
    end
  end

  // R2
  so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (so == 1'b0));
  // R11
  guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && ph == PH_WDATA && got && guard_hit && !wip) |=> !wip);
  // R12
  partial_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && cnt != 3'd0 && !wip) |=> !wip);
endmodule

// File: tb/spi_ee_slave_bench.sv
module spi_ee_slave_bench;
  localparam int TWR = 1200;
  localparam int H   = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so;
  logic mode = 1'b0;

  always #4 clk = ~clk;

  spi_ee_slave #(.MEM_AW(8), .PAGE_AW(5), .TWR_CYC(TWR), .SYNC_STAGES(2)) u_spi_ee_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so)
  );

  int n_chk = 0, n_bad = 0;
  int unsigned cyc = 0;
  int unsigned t_rise = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] mdl [256];
  logic       m_wel = 1'b0;
  logic [1:0] m_bp  = 2'b00;
  logic [7:0] dbuf [64];
  logic [7:0] rbuf [64];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic guard_m(input logic [1:0] b, input logic [7:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a >= 8'hC0;
      2'b10:   return a >= 8'h80;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] st_m(input logic busy);
    return {4'b0000, m_bp, m_wel, busy};
  endfunction

  task automatic txbit(input logic b, output logic r);
    @(negedge clk) sck = 1'b0; si = b;
    repeat (H) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic txb(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) txbit(tx[i], rx[i]);
  endtask

  task automatic sel();
    @(negedge clk) sck = mode;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk) sck = mode;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    t_rise = cyc;
    repeat (12) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] o);
    logic [7:0] d;
    sel(); txb(o, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); txb(8'h05, d); txb(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); txb(8'h01, d); txb(v, d); desel();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] d;
    sel(); txb(8'h03, d); txb(a[15:8], d); txb(a[7:0], d);
    for (int i = 0; i < n; i++) txb(8'h00, rbuf[i]);
    desel();
  endtask

  task automatic wr(input logic [15:0] a, input int n, input int extra);
    logic [7:0] d;
    logic r;
    sel(); txb(8'h02, d); txb(a[15:8], d); txb(a[7:0], d);
    for (int i = 0; i < n; i++) txb(dbuf[i], d);
    for (int i = 0; i < extra; i++) txbit(1'b1, r);
    desel();
  endtask

  task automatic apply_m(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) mdl[{a[7:5], 5'(a[4:0] + 5'(i))}] = dbuf[i];
  endtask

  // polls until not busy; brackets the busy window (R8)
  task automatic wait_ready(input string tag, input int unsigned t0);
    logic [7:0] s;
    int polls = 0;
    s = 8'h01;
    while (s[0] && polls < 20) begin rdsr(s); polls++; end
    chk({tag, " R8 busy window lower"}, 32'(cyc - t0 >= TWR), 1);
    chk({tag, " R8 busy window upper"}, 32'(cyc - t0 <= TWR + 450), 1);
    chk({tag, " R8 status after cycle"}, s, st_m(1'b0));
  endtask

  task automatic check_page(input string tag, input logic [15:0] a);
    logic [15:0] b;
    b = {a[15:5], 5'b0};
    rd(b, 32);
    for (int i = 0; i < 32; i++) chk(tag, rbuf[i], mdl[b[7:0] + 8'(i)]);
  endtask

  task automatic do_write(input string tag, input logic [15:0] a, input int n, input int extra);
    logic [7:0] s;
    int unsigned t0;
    logic go;
    go = m_wel && n > 0 && extra == 0 && !guard_m(m_bp, a[7:0]);
    wr(a, n, extra);
    t0 = t_rise;
    rdsr(s);
    chk({tag, " R6 R11 R12 status after write"}, s, st_m(go));
    if (go) begin
      m_wel = 1'b0;
      apply_m(a, n);
      wait_ready(tag, t0);
    end
  endtask

  task automatic do_wrsr(input string tag, input logic [7:0] v);
    logic [7:0] s;
    int unsigned t0;
    logic go;
    go = m_wel;
    wrsr(v);
    t0 = t_rise;
    rdsr(s);
    chk({tag, " R10 R7 status after status write"}, s, st_m(go));
    if (go) begin
      m_wel = 1'b0;
      m_bp = v[3:2];
      wait_ready(tag, t0);
    end
  endtask

  task automatic wren();
    op1(8'h06); m_wel = 1'b1;
  endtask

  task automatic wrdi();
    op1(8'h04); m_wel = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom_range(1, 255));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int unsigned t0;
    void'($urandom(32'd91));
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 so after reset", so, 0);
    rdsr(s);
    chk("R1 R3 status after reset", s, 8'h00);
    rd(16'h00F0, 4);
    for (int i = 0; i < 4; i++) chk("R1 R5 array after reset", rbuf[i], 8'h00);

    // R7 write without latch
    fill(4);
    do_write("R7 no latch", 16'h0010, 4, 0);
    check_page("R7 page unchanged", 16'h0010);

    // R4 latch set and clear
    wren(); rdsr(s); chk("R4 latch set", s, 8'h02);
    wrdi(); rdsr(s); chk("R4 latch cleared", s, 8'h00);

    // R6 R8 R9: wrapping write, then busy-time commands
    wren();
    fill(8);
    wr(16'h001C, 8, 0);
    t0 = t_rise;
    rdsr(s); chk("R8 R3 busy status", s, 8'h03);
    rd(16'h001C, 2);
    chk("R9 read while busy", rbuf[0], 8'h00);
    chk("R9 read while busy", rbuf[1], 8'h00);
    m_wel = 1'b0;
    apply_m(16'h001C, 8);
    fill(2);
    wr(16'h0040, 2, 0);
    wait_ready("R8 first write", t0);
    check_page("R6 wrapped page", 16'h0000);
    check_page("R9 ignored write", 16'h0040);

    // R6 more than one page of data
    wren(); fill(36);
    do_write("R6 overflow", 16'h0025, 36, 0);
    check_page("R6 overflow page", 16'h0020);

    // R5 read wraps at the array end, upper address bits ignored
    wren(); fill(4);
    do_write("R5 setup", 16'h00FE, 4, 0);
    rd(16'h73FE, 4);
    chk("R5 wrap byte 0", rbuf[0], mdl[8'hFE]);
    chk("R5 wrap byte 1", rbuf[1], mdl[8'hFF]);
    chk("R5 wrap byte 2", rbuf[2], mdl[8'h00]);
    chk("R5 wrap byte 3", rbuf[3], mdl[8'h01]);

    // R12 partial byte, empty write, unknown opcode
    wren(); fill(1);
    do_write("R12 partial", 16'h0060, 1, 3);
    do_write("R12 empty", 16'h0060, 0, 0);
    op1(8'hAB); rdsr(s); chk("R12 unknown opcode", s, 8'h02);
    check_page("R12 page unchanged", 16'h0060);
    wrdi();

    // R7 R10 status writes
    do_wrsr("R7 status no latch", 8'hFF);
    wren(); do_wrsr("R10 status all", 8'hFF);
    chk("R10 guard bits only", {6'b0, m_bp}, 3);
    wren(); do_wrsr("R10 guard quarter", 8'h04);

    // R11 guarded regions
    wren(); fill(3);
    do_write("R11 quarter blocked", 16'h00C4, 3, 0);
    check_page("R11 quarter page", 16'h00C0);
    do_write("R11 quarter open", 16'h00A4, 3, 0);
    check_page("R11 open page", 16'h00A0);
    wren(); do_wrsr("R11 half", 8'h08);
    wren(); fill(2);
    do_write("R11 half blocked", 16'h0088, 2, 0);
    wrdi();
    wren(); do_wrsr("R11 all", 8'h0C);
    wren(); fill(2);
    do_write("R11 all blocked", 16'h0004, 2, 0);
    check_page("R11 all page", 16'h0000);
    do_wrsr("R11 clear", 8'h00);

    // R2 idle-high clock
    mode = 1'b1;
    wren(); fill(5);
    do_write("R2 idle high", 16'h0033, 5, 0);
    check_page("R2 idle high page", 16'h0020);
    chk("R2 so idle", so, 0);

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic [15:0] a;
      int n;
      mode = 1'($urandom_range(0, 1));
      if (($urandom % 3) == 0) begin
        wren(); do_wrsr("R10 random status", 8'($urandom));
      end
      a = 16'($urandom);
      n = $urandom_range(1, 36);
      fill(n);
      wren();
      do_write("R6 R11 random", a, n, 0);
      if (m_wel) wrdi();
      check_page("R2 R6 random page", a);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule